// File: doc/BRIEF.md
# Event-Armed Block Transfer Channel

This block is a single transfer channel. It moves data in fixed 128-byte blocks from system memory into an audio write FIFO. Software loads a source start address, a destination start address and a block count. It then writes a kick word that carries a trigger-event code. Once kicked, the channel waits for the chosen hardware event line. It checks that both memory targets are supported, then runs one read/write handshake pair for each block. After a short notification phase it drops back to idle and fires a one-cycle completion pulse.

A three-bit status code shows the progress of a request at all times. Idle has three flavours: finished, cleared and rejected. A global clear input aborts a request wherever it is and still fires the completion pulse. All configuration words are frozen while a request is in flight.

Each block is modelled as one data beat. The channel asks memory for the block at its current source address. It holds the returned data and offers it to the FIFO at the matching destination address.

Top module: `evt_block_dma`

## Requirements
- R1: Writing the kick word (cfgSel 0) with bit 0 set while no request is in flight starts a request. reqBusy then reads 1 while the status is 1, 2, 3 or 4, and reads 0 otherwise.
- R2: The kick word carries a 5-bit trigger code in bits [20:16]. Code 0 makes the status 2 in the cycle after the kick. Any other code c gives status 1, which lasts until eventIn[c] is high at a clock edge; the status is 2 after that edge. Other event lines have no effect.
- R3: The status codes are 0 finished, 1 awaiting event, 2 event seen, 3 moving data, 4 notifying, 5 cleared and 6 rejected. Status 2 lasts exactly one cycle, and reset leaves status 0.
- R4: A source write (cfgSel 1) or destination write (cfgSel 2) keeps bits [31:7] as the start address and bits [1:0] as the target, and discards bits [6:2]. Block k is read at source start + 128*k and written at destination start + 128*k.
- R5: A size write (cfgSel 3) keeps bits [6:0] as the block count minus one. A request moves exactly that value plus one blocks, so 0 moves one block.
- R6: A request moves to status 3 only if the source target is 2 and the destination target is 1. Otherwise status 2 is followed by status 6, with no memory request and no completion pulse.
- R7: clearIn high at an edge while a request is in flight gives status 5 and donePulse high in the next cycle, with both requests low. clearIn while no request is in flight has no effect.
- R8: Source, destination, size and kick writes made while a request is in flight are ignored.
- R9: Status 4 lasts NOTE_LEN cycles (2 by default). It is followed by status 0, with donePulse high for exactly that one cycle.
- R10: memRdReq stays high until memRdValid is seen at an edge. The data captured then is presented on fifoWrData, with fifoWrReq held high until fifoWrAck is seen at an edge.
- R11: From status 5 or 6, a new kick starts a request exactly as it does from status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Word select: 0 kick, 1 source, 2 destination, 3 size |
| cfgWdata | input | 32 | Configuration write data |
| eventIn | input | 32 | Hardware event lines, indexed by trigger code |
| clearIn | input | 1 | Global abort |
| memRdReq | output | 1 | Block read request to memory |
| memRdAddr | output | 32 | Byte address of the block being read |
| memRdValid | input | 1 | Memory returns read data |
| memRdData | input | 32 | Read data |
| fifoWrReq | output | 1 | Block write request to the FIFO |
| fifoWrAddr | output | 32 | Byte address of the block being written |
| fifoWrData | output | 32 | Write data |
| fifoWrAck | input | 1 | FIFO accepts the write |
| statusCode | output | 3 | Progress code |
| reqBusy | output | 1 | Request bit readback |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that the event-seen state lasts one cycle and that data transfer is only entered from it. They also check that a clear in flight always yields the cleared code with a pulse, that the pulse never lasts two cycles, and that a read request is held until it is answered. They further check that configuration stays frozen while the channel is busy and that the block index never passes the programmed count. Only the bench scenarios can show the numeric results: the correct block addresses, the exact number of blocks for a given size, which event line arms a request, and whether a rejected, cleared or restarted request behaves as the requirements state. The bench also varies the memory and FIFO latency.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [2:0] {
    ST_DONE = 3'd0,
    ST_WAIT = 3'd1,
    ST_PEND = 3'd2,
    ST_XFER = 3'd3,
    ST_NOTE = 3'd4,
    ST_CLR  = 3'd5,
    ST_ERR  = 3'd6
  } dmaStatusE;

  typedef struct packed {
    logic cfgAllow;
    logic startXfer;
    logic captureRd;
    logic advanceBlk;
  } dpStrobeT;

  localparam logic [1:0] SEL_KICK = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;
  localparam logic [1:0] SEL_SIZE = 2'd3;

  localparam logic [1:0] TGT_SYSMEM = 2'd2;
  localparam logic [1:0] TGT_AFIFO  = 2'd1;

endpackage

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int EVT_W    = 5,
  parameter int NOTE_LEN = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgSel,
  input  logic                  kickBit,
  input  logic [EVT_W-1:0]      kickEvt,
  input  logic [(1<<EVT_W)-1:0] eventIn,
  input  logic                  clearIn,
  input  logic                  memRdValid,
  input  logic                  fifoWrAck,
  input  logic                  lastBlk,
  input  logic                  targetsOk,
  output dpStrobeT              strb,
  output dmaStatusE             state,
  output logic                  reqBusy,
  output logic                  memRdReq,
  output logic                  fifoWrReq,
  output logic                  donePulse
);

  localparam int NOTE_W = (NOTE_LEN > 1) ? $clog2(NOTE_LEN) : 1;
  localparam logic [NOTE_W-1:0] NOTE_LAST = NOTE_W'(NOTE_LEN - 1);

  dmaStatusE         st, stN;
  logic              phaseWr, phN;
  logic [NOTE_W-1:0] noteCnt, ntN;
  logic [EVT_W-1:0]  evSel, evN;
  logic              pulseN;
  logic              busy, kickHit;

  assign busy    = (st == ST_WAIT) || (st == ST_PEND) || (st == ST_XFER) || (st == ST_NOTE);
  assign kickHit = cfgWe && (cfgSel == SEL_KICK) && kickBit && !busy;

  always_comb begin
    stN    = st;
    phN    = phaseWr;
    ntN    = noteCnt;
    evN    = evSel;
    pulseN = 1'b0;
    strb   = '0;
    strb.cfgAllow = !busy;
    if (clearIn && busy) begin
      stN    = ST_CLR;
      phN    = 1'b0;
      pulseN = 1'b1;
    end else begin
      unique case (st)
        ST_WAIT: if (eventIn[evSel]) stN = ST_PEND;
        ST_PEND: begin
          if (targetsOk) begin
            stN = ST_XFER;
            phN = 1'b0;
            strb.startXfer = 1'b1;
          end else begin
            stN = ST_ERR;
          end
        end
        ST_XFER: begin
          if (!phaseWr) begin
            if (memRdValid) begin
              strb.captureRd = 1'b1;
              phN = 1'b1;
            end
          end else if (fifoWrAck) begin
            phN = 1'b0;
            if (lastBlk) begin
              stN = ST_NOTE;
              ntN = '0;
            end else begin
              strb.advanceBlk = 1'b1;
            end
          end
        end
        ST_NOTE: begin
          if (noteCnt == NOTE_LAST) begin
            stN    = ST_DONE;
            pulseN = 1'b1;
          end else begin
            ntN = noteCnt + 1'b1;
          end
        end
        default: begin
          if (kickHit) begin
            evN = kickEvt;
            stN = (kickEvt == '0) ? ST_PEND : ST_WAIT;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= ST_DONE;
      phaseWr   <= 1'b0;
      noteCnt   <= '0;
      evSel     <= '0;
      donePulse <= 1'b0;
    end else begin
      st        <= stN;
      phaseWr   <= phN;
      noteCnt   <= ntN;
      evSel     <= evN;
      donePulse <= pulseN;
    end
  end

  assign state     = st;
  assign reqBusy   = busy;
  assign memRdReq  = (st == ST_XFER) && !phaseWr;
  assign fifoWrReq = (st == ST_XFER) && phaseWr;

  // R3: the event-seen state never lasts two cycles
  assert_pend_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    st == ST_PEND |=> st != ST_PEND);

  // R6: data movement is only entered from the validation cycle
  assert_xfer_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_XFER && $past(st) != ST_XFER) |-> $past(st) == ST_PEND);

  // R7: an abort in flight always lands in the cleared state with a pulse
  assert_clear_lands_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clearIn && reqBusy) |=> (st == ST_CLR && donePulse));

  // R9: completion pulse is a single cycle
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R10: a read request is held until it is answered
  assert_rd_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdValid && !clearIn) |=> memRdReq);

endmodule

// File: rtl/dmach_datapath.sv
module dmach_datapath
  import dmach_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 7,
  parameter int CNT_W     = 7,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobeT                     strb,
  input  logic                         cfgWe,
  input  logic [1:0]                   cfgSel,
  input  logic [ADDR_W-BLK_SHIFT-1:0]  cfgStart,
  input  logic [1:0]                   cfgTgt,
  input  logic [CNT_W-1:0]             cfgCnt,
  input  logic [DATA_W-1:0]            memRdData,
  output logic [ADDR_W-1:0]            memRdAddr,
  output logic [ADDR_W-1:0]            fifoWrAddr,
  output logic [DATA_W-1:0]            fifoWrData,
  output logic                         lastBlk,
  output logic                         targetsOk
);

  localparam int START_W = ADDR_W - BLK_SHIFT;

  logic [START_W-1:0] srcStart, dstStart;
  logic [1:0]         srcTgt, dstTgt;
  logic [CNT_W-1:0]   sizeReg, blkIdx;
  logic [DATA_W-1:0]  dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcStart <= '0;
      dstStart <= '0;
      srcTgt   <= '0;
      dstTgt   <= '0;
      sizeReg  <= '0;
      blkIdx   <= '0;
      dataReg  <= '0;
    end else begin
      if (strb.cfgAllow && cfgWe) begin
        unique case (cfgSel)
          SEL_SRC:  begin srcStart <= cfgStart; srcTgt <= cfgTgt; end
          SEL_DST:  begin dstStart <= cfgStart; dstTgt <= cfgTgt; end
          SEL_SIZE: sizeReg <= cfgCnt;
          default:  ;
        endcase
      end
      if (strb.startXfer)       blkIdx <= '0;
      else if (strb.advanceBlk) blkIdx <= blkIdx + 1'b1;
      if (strb.captureRd) dataReg <= memRdData;
    end
  end

  assign memRdAddr  = {srcStart + START_W'(blkIdx), {BLK_SHIFT{1'b0}}};
  assign fifoWrAddr = {dstStart + START_W'(blkIdx), {BLK_SHIFT{1'b0}}};
  assign fifoWrData = dataReg;
  assign lastBlk    = (blkIdx == sizeReg);
  assign targetsOk  = (srcTgt == TGT_SYSMEM) && (dstTgt == TGT_AFIFO);

  // R8: configuration is frozen while a request is in flight
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgAllow |=> ($stable(srcStart) && $stable(dstStart) && $stable(sizeReg)
                        && $stable(srcTgt) && $stable(dstTgt)));

  // R5: the block index never steps past the programmed count
  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.advanceBlk |-> blkIdx < sizeReg);

endmodule

// File: rtl/evt_block_dma.sv
module evt_block_dma
  import dmach_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 7,
  parameter int CNT_W     = 7,
  parameter int DATA_W    = 32,
  parameter int EVT_W     = 5,
  parameter int NOTE_LEN  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgSel,
  input  logic [ADDR_W-1:0]     cfgWdata,
  input  logic [(1<<EVT_W)-1:0] eventIn,
  input  logic                  clearIn,
  output logic                  memRdReq,
  output logic [ADDR_W-1:0]     memRdAddr,
  input  logic                  memRdValid,
  input  logic [DATA_W-1:0]     memRdData,
  output logic                  fifoWrReq,
  output logic [ADDR_W-1:0]     fifoWrAddr,
  output logic [DATA_W-1:0]     fifoWrData,
  input  logic                  fifoWrAck,
  output logic [2:0]            statusCode,
  output logic                  reqBusy,
  output logic                  donePulse
);

  localparam int EVT_LSB = 16;

  dpStrobeT  strb;
  dmaStatusE state;
  logic      lastBlk, targetsOk;

  dmach_ctrl #(.EVT_W(EVT_W), .NOTE_LEN(NOTE_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .kickBit(cfgWdata[0]), .kickEvt(cfgWdata[EVT_LSB +: EVT_W]),
    .eventIn(eventIn), .clearIn(clearIn), .memRdValid(memRdValid),
    .fifoWrAck(fifoWrAck), .lastBlk(lastBlk), .targetsOk(targetsOk),
    .strb(strb), .state(state), .reqBusy(reqBusy), .memRdReq(memRdReq),
    .fifoWrReq(fifoWrReq), .donePulse(donePulse)
  );

  dmach_datapath #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .CNT_W(CNT_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgStart(cfgWdata[ADDR_W-1:BLK_SHIFT]), .cfgTgt(cfgWdata[1:0]),
    .cfgCnt(cfgWdata[CNT_W-1:0]), .memRdData(memRdData),
    .memRdAddr(memRdAddr), .fifoWrAddr(fifoWrAddr), .fifoWrData(fifoWrData),
    .lastBlk(lastBlk), .targetsOk(targetsOk)
  );

  assign statusCode = state;

endmodule

// File: tb/evt_block_dma_test.sv
module evt_block_dma_test;

  localparam int CLK_PERIOD = 10;
  localparam int NOTE_LEN   = 2;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] eventIn = '0;
  logic        clearIn = 1'b0;
  logic        memRdReq, fifoWrReq, donePulse, reqBusy;
  logic [31:0] memRdAddr, fifoWrAddr, fifoWrData;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        fifoWrAck = 1'b0;
  logic [2:0]  statusCode;

  evt_block_dma #(.NOTE_LEN(NOTE_LEN)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .eventIn(eventIn), .clearIn(clearIn), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .fifoWrReq(fifoWrReq),
    .fifoWrAddr(fifoWrAddr), .fifoWrData(fifoWrData), .fifoWrAck(fifoWrAck),
    .statusCode(statusCode), .reqBusy(reqBusy), .donePulse(donePulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // behavioural reference model
  int          mSt = 0, mNote = 0;
  bit          mPh = 0, mPulse = 0;
  logic [31:0] mSrc = '0, mDst = '0, mData = '0;
  int          mSize = 0, mIdx = 0, mEv = 0;

  always @(posedge clk) begin
    bit busy, pulse;
    if (!rstN) begin
      mSt = 0; mPh = 0; mNote = 0; mPulse = 0; mSrc = '0; mDst = '0;
      mData = '0; mSize = 0; mIdx = 0; mEv = 0;
    end else begin
      busy  = (mSt >= 1 && mSt <= 4);
      pulse = 0;
      if (clearIn && busy) begin
        mSt = 5; mPh = 0; pulse = 1;
      end else begin
        if (!busy && cfgWe) begin
          if (cfgSel == 2'd1) mSrc = cfgWdata;
          if (cfgSel == 2'd2) mDst = cfgWdata;
          if (cfgSel == 2'd3) mSize = int'(cfgWdata[6:0]);
        end
        case (mSt)
          1: if (eventIn[mEv]) mSt = 2;
          2: if (mSrc[1:0] == 2'd2 && mDst[1:0] == 2'd1) begin
               mSt = 3; mIdx = 0; mPh = 0;
             end else mSt = 6;
          3: if (!mPh) begin
               if (memRdValid) begin mData = memRdData; mPh = 1; end
             end else if (fifoWrAck) begin
               mPh = 0;
               if (mIdx == mSize) begin mSt = 4; mNote = 0; end
               else mIdx++;
             end
          4: if (mNote == NOTE_LEN - 1) begin mSt = 0; pulse = 1; end
             else mNote++;
          default: if (cfgWe && cfgSel == 2'd0 && cfgWdata[0]) begin
               mEv = int'(cfgWdata[20:16]);
               mSt = (mEv == 0) ? 2 : 1;
             end
        endcase
      end
      mPulse = pulse;
    end
  end

  function automatic logic [31:0] blkAddr(logic [31:0] base, int idx);
    logic [31:0] s;
    s = (base >> 7) + idx;
    return s << 7;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3 status", {29'd0, statusCode}, mSt);
      chk("R1 busy", {31'd0, reqBusy}, (mSt >= 1 && mSt <= 4));
      chk("R10 rdReq", {31'd0, memRdReq}, (mSt == 3 && !mPh));
      chk("R10 wrReq", {31'd0, fifoWrReq}, (mSt == 3 && mPh));
      chk("R9 pulse", {31'd0, donePulse}, mPulse);
      if (mSt == 3 && !mPh) chk("R4 rdAddr", memRdAddr, blkAddr(mSrc, mIdx));
      if (mSt == 3 && mPh) begin
        chk("R4 wrAddr", fifoWrAddr, blkAddr(mDst, mIdx));
        chk("R10 wrData", fifoWrData, mData);
      end
    end
  end

  // memory and FIFO responders
  int lat = 0, rdWait = 0, wrWait = 0;
  int rdCount = 0, wrCount = 0, pulses = 0;
  logic [31:0] firstRdAddr = '0, lastRdAddr = '0, lastWrAddr = '0;

  always @(negedge clk) begin
    memRdValid = 1'b0;
    fifoWrAck  = 1'b0;
    if (donePulse) pulses++;
    if (memRdReq) begin
      if (rdWait >= lat) begin
        memRdValid = 1'b1;
        memRdData  = memRdAddr ^ 32'h5A5A_0000;
        if (rdCount == 0) firstRdAddr = memRdAddr;
        lastRdAddr = memRdAddr;
        rdCount++;
        rdWait = 0;
      end else rdWait++;
    end else rdWait = 0;
    if (fifoWrReq) begin
      if (wrWait >= lat) begin
        fifoWrAck  = 1'b1;
        lastWrAddr = fifoWrAddr;
        wrCount++;
        wrWait = 0;
      end else wrWait++;
    end else wrWait = 0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0; cfgWdata = '0;
  endtask

  task automatic clearPulse();
    @(negedge clk);
    clearIn = 1'b1;
    @(negedge clk);
    clearIn = 1'b0;
  endtask

  task automatic waitStat(string req, logic [2:0] v);
    for (int i = 0; i < 2000; i++) begin
      if (statusCode == v) break;
      @(negedge clk);
    end
    chk(req, {29'd0, statusCode}, {29'd0, v});
  endtask

  task automatic resetCounts();
    rdCount = 0; wrCount = 0; pulses = 0;
  endtask

  initial begin
    cyc(3);
    @(negedge clk) rstN = 1'b1;
    cyc(1);
    chk("R3 reset status", {29'd0, statusCode}, 0);
    chk("R1 reset busy", {31'd0, reqBusy}, 0);

    // R6: kick with reset targets is rejected
    resetCounts();
    wr(2'd0, 32'h0000_0001);
    chk("R2 immediate start", {29'd0, statusCode}, 2);
    cyc(1);
    chk("R6 rejected", {29'd0, statusCode}, 6);
    cyc(3);
    chk("R6 no read", rdCount, 0);
    chk("R6 no pulse", pulses, 0);

    // R4, R5: three blocks, zero latency, junk in bits 6:2
    wr(2'd1, 32'h0001_007E);
    wr(2'd2, 32'h0004_0001);
    wr(2'd3, 32'h0000_0002);
    resetCounts();
    lat = 0;
    wr(2'd0, 32'h0000_0001);
    chk("R11 start from error", {29'd0, statusCode}, 2);
    waitStat("R9 back to done", 3'd0);
    cyc(2);
    chk("R5 reads", rdCount, 3);
    chk("R5 writes", wrCount, 3);
    chk("R4 first read addr", firstRdAddr, 32'h0001_0000);
    chk("R4 last read addr", lastRdAddr, 32'h0001_0100);
    chk("R4 last write addr", lastWrAddr, 32'h0004_0100);
    chk("R9 one pulse", pulses, 1);

    // R2, R8: event-armed request with latency
    resetCounts();
    lat = 2;
    wr(2'd0, 32'h0005_0001);
    chk("R2 awaiting", {29'd0, statusCode}, 1);
    eventIn[6] = 1'b1;
    cyc(4);
    chk("R2 other line ignored", {29'd0, statusCode}, 1);
    eventIn[6] = 1'b0;
    wr(2'd3, 32'h0000_007F);
    wr(2'd1, 32'h0009_0002);
    wr(2'd0, 32'h0000_0001);
    chk("R8 kick ignored", {29'd0, statusCode}, 1);
    eventIn[5] = 1'b1;
    cyc(1);
    eventIn[5] = 1'b0;
    chk("R2 event seen", {29'd0, statusCode}, 2);
    cyc(1);
    chk("R3 moving", {29'd0, statusCode}, 3);
    waitStat("R9 done after event", 3'd0);
    cyc(2);
    chk("R8 size unchanged", rdCount, 3);
    chk("R8 source unchanged", firstRdAddr, 32'h0001_0000);

    // R7: abort mid transfer
    wr(2'd3, 32'h0000_0005);
    resetCounts();
    lat = 1;
    wr(2'd0, 32'h0000_0001);
    while (rdCount < 2) @(negedge clk);
    clearPulse();
    chk("R7 cleared", {29'd0, statusCode}, 5);
    chk("R7 pulse", {31'd0, donePulse}, 1);
    chk("R7 no read req", {31'd0, memRdReq}, 0);
    chk("R7 no write req", {31'd0, fifoWrReq}, 0);
    cyc(3);
    clearPulse();
    cyc(2);
    chk("R7 idle clear status", {29'd0, statusCode}, 5);
    chk("R7 idle clear no pulse", pulses, 1);

    // R11, R5: restart from cleared with a single block
    wr(2'd3, 32'h0000_0000);
    resetCounts();
    wr(2'd0, 32'h0000_0001);
    chk("R11 start from cleared", {29'd0, statusCode}, 2);
    waitStat("R9 single done", 3'd0);
    cyc(2);
    chk("R5 single block", rdCount, 1);

    // R6: bad destination target, then restart
    wr(2'd2, 32'h0004_0003);
    resetCounts();
    wr(2'd0, 32'h0000_0001);
    cyc(1);
    chk("R6 bad destination", {29'd0, statusCode}, 6);
    chk("R6 no read after reject", rdCount, 0);
    wr(2'd2, 32'h0004_0001);
    wr(2'd0, 32'h0000_0001);
    chk("R11 restart after reject", {29'd0, statusCode}, 2);
    waitStat("R9 restart done", 3'd0);

    // R7: abort while awaiting an event
    resetCounts();
    wr(2'd0, 32'h0009_0001);
    chk("R2 awaiting line 9", {29'd0, statusCode}, 1);
    clearPulse();
    chk("R7 clear while waiting", {29'd0, statusCode}, 5);
    chk("R7 pulse while waiting", {31'd0, donePulse}, 1);
    cyc(3);
    summary();
  end

endmodule